// File: doc/BRIEF.md
# LRU Set-Associative Tag Directory

This block holds the tag state of a set-associative cache: one tag, a valid bit, a dirty bit and a recency rank for every way of every set. It holds no line data. A byte address is split into a line offset, which is ignored, a set index and a tag. Four operations are offered, one per request, over a valid/ready handshake: lookup with optional dirty marking, eviction of the least-recently-used line of a full set, insertion of a new line, and removal of a named line that reports whether it was dirty.

Recency is kept as a rank per way. Rank 0 is most recently used and rank WAYS-1 is least recently used. The ranks of a set always form a permutation. A way that is freed by eviction or removal is moved to the oldest rank, so the next insertion into that set reuses it. Each accepted request updates its set on the clock edge that accepts it. The response is registered and appears one cycle later. A controller uses the directory to decide hits, to find which dirty lines must be written back, and to hand lines to another level when the hierarchy is exclusive.

Top module: `lru_tag_dir`

## Requirements
- R1: `req_ready_o` is high from the first clock edge after reset release. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `rsp_valid_o` is high for exactly the one cycle that follows each accepted request and is low otherwise.
- R2: The address bits [LINE_LG-1:0] are ignored. The set index is bits [LINE_LG+IDX_W-1:LINE_LG], where IDX_W = CAP_LG-LINE_LG-log2(WAYS). The tag is every bit above the index. With the defaults this gives 4 offset bits, 4 index bits and a 24-bit tag.
- R3: `req_op_i` selects the operation: 0 is lookup, 1 is evict, 2 is insert, 3 is remove.
- R4: A lookup sets `rsp_hit_o` when a valid way of the indexed set holds the tag. On a hit, that line becomes most recently used. If `req_dirty_i` is also set, the line's dirty bit is set.
- R5: After reset, every line is invalid and clean, and all response outputs are low.
- R6: An evict on a full set invalidates the least-recently-used line. If that line was dirty, `rsp_victim_valid_o` is 1 and `rsp_victim_addr_o` is {tag, index, LINE_LG zero bits}. A clean victim gives `rsp_victim_valid_o` = 0.
- R7: An evict on a set that is not full changes nothing and reports no victim.
- R8: An insert places the tag at the most-recently-used position, with its dirty bit taken from `req_dirty_i`. If the set is full, the least-recently-used line is dropped without a victim report. The requester guarantees that the tag is not already present.
- R9: A remove of a present tag invalidates that line and returns `rsp_hit_o` = 1 and `rsp_was_dirty_o` = its dirty bit. A remove of an absent tag returns 0 on both outputs and changes nothing.
- R10: After an evict or a remove frees a way, the next insert into that set fills the freed way, and every line that was still valid remains present.
- R11: Response fields that do not belong to an operation are 0. `rsp_hit_o` is 0 for evict and insert. `rsp_victim_valid_o` is 0 for every operation except evict. `rsp_was_dirty_o` is 0 for every operation except remove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Directory can accept a request |
| req_op_i | input | 2 | Operation code (R3) |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_dirty_i | input | 1 | Mark-dirty flag for lookup; dirty value for insert |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Tag found (lookup, remove) |
| rsp_victim_valid_o | output | 1 | Dirty victim evicted |
| rsp_victim_addr_o | output | ADDR_W | Line address of the dirty victim |
| rsp_was_dirty_o | output | 1 | Dirty state of the removed line |

## Verification
A corrupted rank vector shows up at the ports on the next full-set evict or insert. The wrong line disappears, which a later lookup reports as a miss, or a clean victim is reported in place of a dirty one. A lost or stuck dirty bit appears at the next evict or remove of that line, through the victim flag or the was-dirty flag. A bad index or tag split makes lookups in the neighbouring sets hit or miss wrongly on the very next request. For these reasons the directed sequences build a known recency order in each set and then probe the eviction order line by line.

// File: rtl/lru_dir_pkg.sv
package lru_dir_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_EVICT  = 2'd1,
    OP_INSERT = 2'd2,
    OP_REMOVE = 2'd3
  } dir_op_e;
endpackage

// File: rtl/lru_addr_map.sv
module lru_addr_map #(
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 4,
  parameter int IDX_W   = 4,
  localparam int TAG_W  = ADDR_W - LINE_LG - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  vtag_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  assign idx_o   = addr_i[LINE_LG +: IDX_W];
  assign tag_o   = addr_i[ADDR_W-1 -: TAG_W];
  // victim line address rebuilt from stored tag and current index
  assign vaddr_o = {vtag_i, idx_o, {LINE_LG{1'b0}}};
endmodule

// File: rtl/lru_rank_next.sv
module lru_rank_next #(
  parameter int WAYS   = 4,
  localparam int WAY_LG = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_LG-1:0] age_i,
  input  logic [WAY_LG-1:0]           way_i,
  input  logic                        promote_i,
  output logic [WAYS-1:0][WAY_LG-1:0] age_o
);
  localparam logic [WAY_LG-1:0] OLDEST = WAY_LG'(WAYS - 1);
  logic [WAY_LG-1:0] sel_age;
  assign sel_age = age_i[way_i];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_comb begin
      if (WAY_LG'(g) == way_i)
        age_o[g] = promote_i ? '0 : OLDEST;
      else if (promote_i && age_i[g] < sel_age)
        age_o[g] = age_i[g] + 1'b1;
      else if (!promote_i && age_i[g] > sel_age)
        age_o[g] = age_i[g] - 1'b1;
      else
        age_o[g] = age_i[g];
    end
  end
endmodule

// File: rtl/lru_tag_dir.sv
module lru_tag_dir
  import lru_dir_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 4,
  parameter int CAP_LG  = 10,
  parameter int WAYS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_dirty_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_victim_valid_o,
  output logic [ADDR_W-1:0] rsp_victim_addr_o,
  output logic              rsp_was_dirty_o
);
  localparam int WAY_LG = $clog2(WAYS);
  localparam int IDX_W  = CAP_LG - LINE_LG - WAY_LG;
  localparam int SETS   = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - LINE_LG - IDX_W;
  localparam logic [WAY_LG-1:0] OLDEST = WAY_LG'(WAYS - 1);

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [WAYS-1:0][WAY_LG-1:0] age_row_t;

  tag_t             tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  drt_q [SETS];
  age_row_t         age_q [SETS];
  logic             ready_q;

  logic [IDX_W-1:0]  idx;
  tag_t              req_tag, vtag;
  logic [ADDR_W-1:0] vaddr;
  dir_op_e           op;
  logic              accept;

  tag_t             cur_tag [WAYS];
  logic [WAYS-1:0]  cur_vld, cur_drt, match, lru_vec;
  age_row_t         cur_age, age_pro, age_dem;
  logic             hit_any, full;
  logic [WAY_LG-1:0] hit_way, lru_way, pro_way;

  tag_t             nxt_tag [WAYS];
  logic [WAYS-1:0]  nxt_vld, nxt_drt;
  age_row_t         nxt_age;
  logic             d_hit, d_vv, d_wd;

  assign op          = dir_op_e'(req_op_i);
  assign req_ready_o = ready_q;
  assign accept      = req_valid_i && ready_q;

  lru_addr_map #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG), .IDX_W(IDX_W)) u_map (
    .addr_i(req_addr_i), .vtag_i(vtag), .idx_o(idx), .tag_o(req_tag), .vaddr_o(vaddr)
  );

  always_comb begin
    cur_vld = vld_q[idx];
    cur_drt = drt_q[idx];
    cur_age = age_q[idx];
    hit_way = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      cur_tag[w] = tag_q[idx][w];
      match[w]   = cur_vld[w] && (cur_tag[w] == req_tag);
      lru_vec[w] = (cur_age[w] == OLDEST);
      if (match[w])   hit_way = WAY_LG'(w);
      if (lru_vec[w]) lru_way = WAY_LG'(w);
    end
  end

  assign hit_any = |match;
  assign full    = &cur_vld;
  assign pro_way = (op == OP_INSERT) ? lru_way : hit_way;
  assign vtag    = cur_tag[lru_way];

  lru_rank_next #(.WAYS(WAYS)) u_promote (
    .age_i(cur_age), .way_i(pro_way), .promote_i(1'b1), .age_o(age_pro)
  );
  lru_rank_next #(.WAYS(WAYS)) u_demote (
    .age_i(cur_age), .way_i(hit_way), .promote_i(1'b0), .age_o(age_dem)
  );

  always_comb begin
    nxt_tag = cur_tag;
    nxt_vld = cur_vld;
    nxt_drt = cur_drt;
    nxt_age = cur_age;
    d_hit   = 1'b0;
    d_vv    = 1'b0;
    d_wd    = 1'b0;
    unique case (op)
      OP_LOOKUP: if (hit_any) begin
        d_hit   = 1'b1;
        nxt_age = age_pro;
        if (req_dirty_i) nxt_drt[hit_way] = 1'b1;
      end
      OP_EVICT: if (full) begin
        // freed way already holds the oldest rank
        d_vv             = cur_drt[lru_way];
        nxt_vld[lru_way] = 1'b0;
        nxt_drt[lru_way] = 1'b0;
      end
      OP_INSERT: begin
        nxt_tag[lru_way] = req_tag;
        nxt_vld[lru_way] = 1'b1;
        nxt_drt[lru_way] = req_dirty_i;
        nxt_age          = age_pro;
      end
      OP_REMOVE: if (hit_any) begin
        d_hit            = 1'b1;
        d_wd             = cur_drt[hit_way];
        nxt_vld[hit_way] = 1'b0;
        nxt_drt[hit_way] = 1'b0;
        nxt_age          = age_dem;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_LG'(w);
        end
      end
    end else begin
      ready_q <= 1'b1;
      if (accept) begin
        vld_q[idx] <= nxt_vld;
        drt_q[idx] <= nxt_drt;
        age_q[idx] <= nxt_age;
        for (int w = 0; w < WAYS; w++) tag_q[idx][w] <= nxt_tag[w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o        <= 1'b0;
      rsp_hit_o          <= 1'b0;
      rsp_victim_valid_o <= 1'b0;
      rsp_victim_addr_o  <= '0;
      rsp_was_dirty_o    <= 1'b0;
    end else begin
      rsp_valid_o        <= accept;
      rsp_hit_o          <= accept && d_hit;
      rsp_victim_valid_o <= accept && d_vv;
      rsp_victim_addr_o  <= (accept && d_vv) ? vaddr : '0;
      rsp_was_dirty_o    <= accept && d_wd;
    end
  end

  // invalid ways must sit behind every valid way in rank order
  logic [WAY_LG:0] n_valid;
  logic            rank_ok;
  always_comb begin
    n_valid = '0;
    for (int w = 0; w < WAYS; w++) n_valid = n_valid + {{WAY_LG{1'b0}}, cur_vld[w]};
    rank_ok = 1'b1;
    for (int w = 0; w < WAYS; w++)
      if (!cur_vld[w] && ({1'b0, cur_age[w]} < n_valid)) rank_ok = 1'b0;
  end

  a_r1_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);
  a_r1_no_rsp_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rsp_valid_o);
  a_r6_victim_only_on_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_victim_valid_o |-> $past(accept && op == OP_EVICT));
  a_r6_victim_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_victim_valid_o |-> rsp_victim_addr_o[LINE_LG-1:0] == '0);
  a_r9_miss_is_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> !rsp_was_dirty_o);
  a_r11_dirty_only_on_remove: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_was_dirty_o |-> $past(accept && op == OP_REMOVE));
  a_r8_single_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lru_vec) == 1);
  a_r10_free_ways_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_ok);
endmodule

// File: tb/lru_tag_dir_test.sv
module lru_tag_dir_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 32;
  localparam logic [1:0] LK = 2'd0, EV = 2'd1, IN = 2'd2, RM = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_dirty_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_hit_o, rsp_victim_valid_o, rsp_was_dirty_o;
  logic [ADDR_W-1:0] rsp_victim_addr_o;
  int checks = 0, errors = 0;
  logic r_hit, r_vv, r_wd;
  logic [ADDR_W-1:0] r_va;

  always #10 clk = ~clk;

  lru_tag_dir uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_dirty_i(req_dirty_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_victim_valid_o(rsp_victim_valid_o),
    .rsp_victim_addr_o(rsp_victim_addr_o), .rsp_was_dirty_o(rsp_was_dirty_o)
  );

  function automatic logic [ADDR_W-1:0] mk(int t, int s, int off);
    return {t[23:0], s[3:0], off[3:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(logic [1:0] o, logic [ADDR_W-1:0] a, logic d);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = o; req_addr_i = a; req_dirty_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_dirty_i = 1'b0;
    chk("R1 rsp_valid", rsp_valid_o, 1);
    r_hit = rsp_hit_o; r_vv = rsp_victim_valid_o; r_va = rsp_victim_addr_o; r_wd = rsp_was_dirty_o;
  endtask

  task automatic lookup_exp(int t, int s, logic exp, string req);
    op(LK, mk(t, s, 0), 1'b0);
    chk(req, r_hit, exp);
  endtask

  task automatic t_reset;
    chk("R5 rsp_valid in reset", rsp_valid_o, 0);
    chk("R5 hit in reset", rsp_hit_o, 0);
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready_o, 1);
    chk("R1 no rsp idle", rsp_valid_o, 0);
    op(LK, mk(0, 0, 0), 1'b0);
    chk("R5 empty after reset", r_hit, 0);
    @(negedge clk);
    chk("R1 rsp one cycle", rsp_valid_o, 0);
  endtask

  task automatic t_split;
    op(IN, mk('h1234, 1, 0), 1'b0);
    chk("R11 insert hit zero", r_hit, 0);
    chk("R11 insert victim zero", r_vv, 0);
    lookup_exp('h1234, 1, 1, "R4 lookup hit");
    op(LK, mk('h1234, 1, 'hf), 1'b0);
    chk("R2 offset ignored", r_hit, 1);
    chk("R11 lookup was_dirty zero", r_wd, 0);
    lookup_exp('h1235, 1, 0, "R2 tag compare");
    lookup_exp('h1234, 0, 0, "R2 index select");
  endtask

  task automatic t_lru_order;
    for (int i = 0; i < 4; i++) op(IN, mk('h100 + i, 2, 0), 1'b0);
    op(LK, mk('h100, 2, 0), 1'b1);   // order: 100d,103,102,101
    op(EV, mk('h999, 2, 0), 1'b0);
    chk("R6 clean victim", r_vv, 0);
    chk("R11 evict hit zero", r_hit, 0);
    lookup_exp('h101, 2, 0, "R6 LRU removed");
    lookup_exp('h100, 2, 1, "R4 promoted kept");
    op(IN, mk('h104, 2, 0), 1'b0);
    lookup_exp('h103, 2, 1, "R10 line kept");
    lookup_exp('h102, 2, 1, "R10 line kept");
    lookup_exp('h104, 2, 1, "R8 inserted");
    op(EV, mk(0, 2, 0), 1'b0);       // oldest is 100 (dirty)
    chk("R6 dirty victim flag", r_vv, 1);
    chk("R6 victim address", r_va, mk('h100, 2, 0));
    lookup_exp('h100, 2, 0, "R6 dirty victim gone");
  endtask

  task automatic t_evict_not_full;
    op(IN, mk('h200, 3, 0), 1'b1);
    op(IN, mk('h201, 3, 0), 1'b1);
    op(EV, mk(0, 3, 0), 1'b0);
    chk("R7 no victim", r_vv, 0);
    lookup_exp('h200, 3, 1, "R7 line kept");
    lookup_exp('h201, 3, 1, "R7 line kept");
  endtask

  task automatic t_insert_full;
    op(IN, mk('h300, 4, 0), 1'b1);
    for (int i = 1; i < 5; i++) begin
      op(IN, mk('h300 + i, 4, 0), 1'b0);
      chk("R8 no victim report", r_vv, 0);
    end
    lookup_exp('h300, 4, 0, "R8 LRU dropped");
    for (int i = 1; i < 5; i++) lookup_exp('h300 + i, 4, 1, "R8 others kept");
    op(RM, mk('h300, 4, 0), 1'b0);
    chk("R9 absent remove hit", r_hit, 0);
    chk("R9 absent remove clean", r_wd, 0);
  endtask

  task automatic t_remove;
    op(IN, mk('h400, 5, 0), 1'b1);
    op(IN, mk('h401, 5, 0), 1'b0);
    op(RM, mk('h400, 5, 3), 1'b0);
    chk("R9 remove hit", r_hit, 1);
    chk("R9 remove dirty", r_wd, 1);
    op(RM, mk('h401, 5, 0), 1'b0);
    chk("R9 remove clean hit", r_hit, 1);
    chk("R9 remove clean", r_wd, 0);
    op(RM, mk('h400, 5, 0), 1'b0);
    chk("R9 second remove miss", r_hit, 0);
    op(IN, mk('h410, 6, 0), 1'b0);
    op(LK, mk('h410, 6, 0), 1'b1);
    op(RM, mk('h410, 6, 0), 1'b0);
    chk("R4 mark dirty seen by remove", r_wd, 1);
    for (int i = 0; i < 4; i++) op(IN, mk('h500 + i, 7, 0), 1'b0);
    op(RM, mk('h501, 7, 0), 1'b0);
    op(IN, mk('h504, 7, 0), 1'b0);
    lookup_exp('h500, 7, 1, "R10 freed way reused");
    lookup_exp('h502, 7, 1, "R10 freed way reused");
    lookup_exp('h503, 7, 1, "R10 freed way reused");
    lookup_exp('h504, 7, 1, "R10 new line present");
    lookup_exp('h501, 7, 0, "R9 removed line gone");
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_split();
    t_lru_order();
    t_evict_not_full();
    t_insert_full();
    t_remove();
    @(negedge clk);
    chk("R3 idle after ops", rsp_valid_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule